// File: doc/BRIEF.md
# Block-Transfer Configuration Serial Slave

This block is a two-wire serial slave that keeps seven 8-bit configuration registers for the clock control logic next to it. It oversamples the bus clock and data lines with the system clock, cleans them through a synchroniser and a short glitch filter, and finds START and STOP conditions and clock edges on the cleaned lines. It answers to the 7-bit device address 0x69. The read/write flag is the least significant bit of the address byte, so the host sends 0xD2 to write and 0xD3 to read.

The protocol supports block transfers only. A write carries a command byte and a count byte. The slave acknowledges both and throws their values away. The data bytes that follow fill the registers from index 0 upward. A read first returns a fixed count byte of 0x06 and then the registers in ascending order. The register contents drive the `cfg_regs` output at all times. The data line is driven as an open-drain pull-down enable.

Top module: `cfg_serial_slave`

## Requirements
- R1: An address byte whose upper seven bits equal 0x69 is acknowledged. The slave pulls the data line low (`sda_pull` = 1) for the whole ninth clock of that byte, and for the ninth clock of every byte it receives afterwards in a write.
- R2: In a write, the two bytes after the address are acknowledged, and their values have no effect on any register.
- R3: Write data bytes go to registers 0, 1, 2 and so on, in arrival order. Each byte is acknowledged. Register k appears on `cfg_regs[8k+7:8k]`.
- R4: A STOP after any complete byte leaves the registers already written with their new values, and every other register unchanged.
- R5: Data bytes beyond register 6 are acknowledged but stored nowhere.
- R6: A read returns 0x06, then registers 0 to 6 in order, each byte MSB first. The host acknowledges each byte with a low data line in the ninth clock.
- R7: After an address mismatch the slave acknowledges nothing, never drives the data line and changes no register until the next START.
- R8: A high data line (NACK) from the host in the ninth clock of a read byte ends the transmission. The data line is released and stays released until a new START.
- R9: Reset (synchronous, active high) sets register 0 to 0xF0 and registers 1 to 6 to 0x00, and releases the data line.
- R10: `sda_pull` changes only while the bus clock is low.
- R11: A pulse on the bus clock that lasts fewer than `FILT_CYC` system clocks is not taken as a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls the data line low; 0 releases it |
| cfg_regs | output | NREG*8 (56) | Register contents; register k in bits 8k+7..8k |

## Verification
On every cycle the assertions check that the pull-down enable changes only while the filtered clock is low, that the slave never drives the line while idle, that the acknowledge is held throughout the acknowledge phase, that a host NACK releases the line, and that the registers stay unchanged when no write strobe is present. Only the bench scenarios show the behaviour at the byte level. These are the register mapping of the data bytes, the discarded command and count bytes, the dropped overflow bytes, the order of the read stream with its leading count, the silence after an address mismatch, and the rejection of a short clock glitch.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } cfgs_state_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_CMD,
    K_CNT,
    K_DATA
  } cfgs_kind_t;
endpackage

// File: rtl/cfgs_glitch_filter.sv
module cfgs_glitch_filter #(
  parameter int   FILT_CYC = 4,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= RST_VAL;
      s2     <= RST_VAL;
      cnt    <= '0;
      line_o <= RST_VAL;
    end else begin
      s1 <= line_i;
      s2 <= s1;
      if (s2 != line_o) begin
        if (cnt == LAST) begin
          line_o <= s2;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  // R11: the output only moves to a value the synchronised line already held
  assert_filter_settled_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(line_o) |-> (line_o == $past(s2)));
endmodule

// File: rtl/cfgs_regbank.sv
module cfgs_regbank #(
  parameter int         NREG      = 7,
  parameter logic [7:0] REG0_INIT = 8'hF0,
  parameter int         PW        = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [PW-1:0]   wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [PW-1:0]   rd_addr,
  output logic [7:0]      rd_data,
  output logic [NREG*8-1:0] regs_o
);
  logic [7:0] q [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    localparam logic [7:0] INIT = (k == 0) ? REG0_INIT : 8'h00;
    always_ff @(posedge clk) begin
      if (rst)
        q[k] <= INIT;
      else if (wr_en && (wr_addr == PW'(k)))
        q[k] <= wr_data;
    end
    assign regs_o[8*k +: 8] = q[k];
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int k = 0; k < NREG; k++)
      if (rd_addr == PW'(k)) rd_data = q[k];
  end

  // R4: no strobe, no change anywhere in the bank
  assert_hold_unwritten_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs_o));
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
  parameter int         NREG      = 7,
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter logic [7:0] CNT_BYTE  = 8'h06,
  parameter logic [7:0] REG0_INIT = 8'hF0,
  parameter int         FILT_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  output logic [NREG*8-1:0] cfg_regs
);
  import cfgs_pkg::*;

  localparam int PW = $clog2(NREG + 1);
  localparam logic [PW-1:0] NREG_P = PW'(NREG);

  // line conditioning
  logic [1:0] raw_lines, filt_lines;
  assign raw_lines = {scl_in, sda_in};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    cfgs_glitch_filter #(.FILT_CYC(FILT_CYC), .RST_VAL(1'b1)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .line_i (raw_lines[g]),
      .line_o (filt_lines[g])
    );
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  logic scl_rise, scl_fall, start_evt, stop_evt;
  assign scl_rise  =  scl_f & ~scl_q;
  assign scl_fall  = ~scl_f &  scl_q;
  assign start_evt =  scl_f &  scl_q &  sda_q & ~sda_f;
  assign stop_evt  =  scl_f &  scl_q & ~sda_q &  sda_f;

  // protocol state
  cfgs_state_t   state;
  cfgs_kind_t    kind;
  logic          is_read;
  logic          host_ack;
  logic [3:0]    bitcnt;
  logic [7:0]    rx_sh, tx_sh;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [7:0]    rd_data;
  logic          wr_en;

  assign wr_en = (state == ST_RX) && scl_fall && (bitcnt == 4'd8)
                 && (kind == K_DATA) && (wr_ptr < NREG_P);

  cfgs_regbank #(.NREG(NREG), .REG0_INIT(REG0_INIT), .PW(PW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_ptr),
    .wr_data (rx_sh),
    .rd_addr (rd_ptr),
    .rd_data (rd_data),
    .regs_o  (cfg_regs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      kind     <= K_ADDR;
      is_read  <= 1'b0;
      host_ack <= 1'b0;
      bitcnt   <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      sda_pull <= 1'b0;
    end else if (start_evt) begin
      state    <= ST_RX;
      kind     <= K_ADDR;
      bitcnt   <= '0;
      wr_ptr   <= '0;
      host_ack <= 1'b0;
      sda_pull <= 1'b0;
    end else if (stop_evt) begin
      state    <= ST_IDLE;
      sda_pull <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise) begin
            rx_sh  <= {rx_sh[6:0], sda_f};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt <= '0;
            if (kind == K_ADDR && rx_sh[7:1] != DEV_ADDR) begin
              state <= ST_IDLE;
            end else begin
              state    <= ST_RXACK;
              sda_pull <= 1'b1;
            end
            case (kind)
              K_ADDR: begin
                is_read <= rx_sh[0];
                kind    <= K_CMD;
              end
              K_CMD:   kind <= K_CNT;
              K_CNT:   kind <= K_DATA;
              default: if (wr_ptr < NREG_P) wr_ptr <= wr_ptr + 1'b1;
            endcase
          end
        end
        ST_RXACK: begin
          if (scl_fall) begin
            if (is_read) begin
              state    <= ST_TX;
              tx_sh    <= CNT_BYTE;
              sda_pull <= ~CNT_BYTE[7];
              bitcnt   <= 4'd1;
              rd_ptr   <= '0;
            end else begin
              state    <= ST_RX;
              sda_pull <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_pull <= 1'b0;
              state    <= ST_TXACK;
              host_ack <= 1'b0;
            end else begin
              sda_pull <= ~tx_sh[6];
              tx_sh    <= {tx_sh[6:0], 1'b0};
              bitcnt   <= bitcnt + 1'b1;
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            if (sda_f) state <= ST_IDLE;
            else       host_ack <= 1'b1;
          end else if (scl_fall && host_ack) begin
            state    <= ST_TX;
            tx_sh    <= rd_data;
            sda_pull <= ~rd_data[7];
            bitcnt   <= 4'd1;
            if (rd_ptr < NREG_P) rd_ptr <= rd_ptr + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R10: the pull-down moves only while the filtered clock is low
  assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> !scl_f);

  // R7: an idle slave never drives the line
  assert_idle_released_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_pull);

  // R1: the acknowledge is held for the whole acknowledge phase
  assert_ack_held_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RXACK) |-> sda_pull);

  // R8: a host NACK ends the read and releases the line
  assert_nack_release_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TXACK && scl_rise && sda_f && !start_evt && !stop_evt)
      |=> (state == ST_IDLE && !sda_pull));

  // R7: START always rearms address reception
  assert_start_rearm_R7: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (state == ST_RX && bitcnt == 4'd0));
endmodule

// File: tb/test_cfg_serial_slave.sv
module test_cfg_serial_slave;
  localparam int NREG = 7;
  localparam int Q    = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_line;
  logic sda_pull;
  logic [NREG*8-1:0] cfg_regs;

  always #2 clk = ~clk;

  assign sda_line = host_sda & ~sda_pull;

  cfg_serial_slave i_cfg_serial_slave (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl),
    .sda_in   (sda_line),
    .sda_pull (sda_pull),
    .cfg_regs (cfg_regs)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] exp_reg [NREG];

  // stimulus table: command, count, number of data bytes, data bytes
  localparam logic [7:0] VC [4] = '{8'h00, 8'hA5, 8'h07, 8'hFF};
  localparam logic [7:0] VB [4] = '{8'h07, 8'h01, 8'h00, 8'h33};
  localparam int         VN [4] = '{7, 3, 9, 0};
  localparam logic [7:0] VD [4][9] = '{
    '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h00, 8'h00},
    '{8'hC3, 8'h5A, 8'h81, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'h0F, 8'hF0, 8'hAA, 8'h55, 8'h01, 8'h80, 8'hFE, 8'h99, 8'h66},
    '{8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE}
  };

  // R10 monitor: pull-down changes seen while the raw clock is high
  int   r10_bad = 0;
  logic prev_pull = 1'b0;
  always @(negedge clk) begin
    if (!rst && sda_pull != prev_pull && scl) r10_bad++;
    prev_pull <= sda_pull;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; scl = 1'b1; wq(Q);
    host_sda = 1'b0; wq(Q);
    scl = 1'b0; wq(4);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wq(Q);
    scl = 1'b1; wq(Q);
    host_sda = 1'b1; wq(Q);
  endtask

  task automatic bit_out(input logic b, input bit glitch);
    host_sda = b;
    if (glitch) begin
      wq(Q/2); scl = 1'b1; wq(1); scl = 1'b0; wq(Q/2);
    end else begin
      wq(Q);
    end
    scl = 1'b1; wq(Q);
    scl = 1'b0; wq(4);
  endtask

  task automatic bit_in(output logic v);
    host_sda = 1'b1; wq(Q);
    scl = 1'b1; wq(Q/2);
    v = sda_line; wq(Q/2);
    scl = 1'b0; wq(4);
  endtask

  // returns the line level in the ninth clock (0 = acknowledged)
  task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i], glitch);
    bit_in(ack);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      bit_in(v);
      b[i] = v;
    end
    bit_out(nack, 1'b0);
  endtask

  task automatic chk_regs(input string tag);
    for (int k = 0; k < NREG; k++)
      chk(tag, 64'(cfg_regs[8*k +: 8]), 64'(exp_reg[k]));
  endtask

  task automatic write_xfer(input logic [7:0] cmd, input logic [7:0] cnt,
                            input int n, input logic [7:0] d [9]);
    logic ack;
    bus_start();
    send_byte(8'hD2, 1'b0, ack); chk("R1 write address ack", 64'(ack), 64'(0));
    send_byte(cmd, 1'b0, ack);   chk("R2 command ack", 64'(ack), 64'(0));
    send_byte(cnt, 1'b0, ack);   chk("R2 count ack", 64'(ack), 64'(0));
    for (int j = 0; j < n; j++) begin
      send_byte(d[j], 1'b0, ack);
      if (j < NREG) chk("R3 data ack", 64'(ack), 64'(0));
      else          chk("R5 overflow byte ack", 64'(ack), 64'(0));
      if (j < NREG) exp_reg[j] = d[j];
    end
    bus_stop();
  endtask

  task automatic read_all();
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, 1'b0, ack); chk("R1 read address ack", 64'(ack), 64'(0));
    recv_byte(1'b0, b);          chk("R6 count byte", 64'(b), 64'(8'h06));
    for (int k = 0; k < NREG; k++) begin
      recv_byte(1'b0, b);
      chk("R6 read data order", 64'(b), 64'(exp_reg[k]));
    end
    bus_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    logic [7:0] gd [9];
    exp_reg[0] = 8'hF0;
    for (int k = 1; k < NREG; k++) exp_reg[k] = 8'h00;
    wq(5);
    rst = 1'b0;
    wq(5);

    // R9 reset state
    chk_regs("R9 reset defaults");
    chk("R9 line released", 64'(sda_pull), 64'(0));

    // table walk: write then read back (R2 R3 R4 R5 R6)
    for (int i = 0; i < 4; i++) begin
      write_xfer(VC[i], VB[i], VN[i], VD[i]);
      chk_regs("R3/R4 registers after write");
      read_all();
    end

    // R7 address mismatch: nothing acknowledged, nothing stored
    bus_start();
    send_byte(8'hA4, 1'b0, ack); chk("R7 mismatch no ack", 64'(ack), 64'(1));
    send_byte(8'h00, 1'b0, ack); chk("R7 ignored byte no ack", 64'(ack), 64'(1));
    send_byte(8'h00, 1'b0, ack); chk("R7 ignored byte no ack", 64'(ack), 64'(1));
    send_byte(8'h3C, 1'b0, ack); chk("R7 ignored data no ack", 64'(ack), 64'(1));
    bus_stop();
    chk_regs("R7 registers untouched");

    // R8 host NACK ends the read
    bus_start();
    send_byte(8'hD3, 1'b0, ack); chk("R8 read address ack", 64'(ack), 64'(0));
    recv_byte(1'b0, b);          chk("R8 count byte", 64'(b), 64'(8'h06));
    recv_byte(1'b1, b);          chk("R8 first register", 64'(b), 64'(exp_reg[0]));
    wq(10);
    chk("R8 released after nack", 64'(sda_pull), 64'(0));
    recv_byte(1'b1, b);          chk("R8 line idle after nack", 64'(b), 64'(8'hFF));
    bus_stop();

    // R11 short clock pulses inside every low phase are rejected
    for (int j = 0; j < 9; j++) gd[j] = 8'h00;
    bus_start();
    send_byte(8'hD2, 1'b0, ack);
    send_byte(8'h00, 1'b0, ack);
    send_byte(8'h01, 1'b0, ack);
    send_byte(8'h96, 1'b1, ack); chk("R11 glitched byte ack", 64'(ack), 64'(0));
    bus_stop();
    exp_reg[0] = 8'h96;
    chk("R11 byte intact", 64'(cfg_regs[7:0]), 64'(8'h96));
    chk_regs("R11 other registers");

    chk("R10 pull changed with clock high", 64'(r10_bad), 64'(0));

    // R9 reset in service restores defaults
    rst = 1'b1; wq(3); rst = 1'b0; wq(3);
    exp_reg[0] = 8'hF0;
    for (int k = 1; k < NREG; k++) exp_reg[k] = 8'h00;
    chk_regs("R9 defaults after second reset");
    chk("R9 line released after reset", 64'(sda_pull), 64'(0));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule